// File: doc/BRIEF.md
# Tag Group Completion Status Unit

This block tells software which DMA tag groups have finished. Software first loads a tag-group mask, one bit per tag, and then files an update request that chooses when a status word is produced. The completed value is the mask with every bit cleared whose tag still has work outstanding. The command queue supplies that information as a bitmap of pending tags. The queue leaves barrier-class commands out of this bitmap.

An update request either posts the completed value at once or waits for a condition. The "any" condition waits until at least one masked group is done. The "all" condition waits until every masked group is done. A waiting request is tested again in two cases: when the queue reports that commands have retired, and when the mask is rewritten.

The posted word sits in a one-entry channel. A reader raises a request and holds it. The acknowledge comes only while a word is present, so a read of an empty channel stalls. A read that is acknowledged takes the word and empties the channel.

Top module: `tag_status_unit`

## Requirements
- R1: After reset the mask is zero, no conditional request is waiting and the channel count is 0, so a read request is not acknowledged.
- R2: The completed value is the effective mask ANDed with the inverse of `pend_tags`. The effective mask is the word being written in that cycle if `mask_wr_en` is high, and the held mask otherwise.
- R3: An update write with code 0 (immediate) posts the completed value, zero included. The count reads 1 in the cycle after the write.
- R4: An update write with code 1 (any) posts once the completed value is nonzero. It posts at once if the value is already nonzero; otherwise it waits.
- R5: An update write with code 2 (all) posts once the completed value equals the whole effective mask. It posts at once if that already holds; otherwise it waits.
- R6: Every update write empties the channel before any new post, so a previously posted word that has not been read is discarded.
- R7: Once a conditional request has posted, no request is waiting. A later retirement or mask write does not post again.
- R8: A waiting any/all request is tested again in every cycle in which `retire_pulse` is high.
- R9: A waiting any/all request is tested again in every cycle in which the mask is written, using the new mask.
- R10: A change of `pend_tags` with no retirement, no mask write and no update write never posts.
- R11: `stat_rd_ack` is high only while `stat_rd_req` is high and the count is 1. While it is high, `stat_rd_data` carries the posted word, and the count is 0 after that edge unless a new post occurs in the same cycle.
- R12: An update write with code 3 (cancel) empties the channel, posts nothing and leaves no request waiting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mask_wr_en | input | 1 | Write the tag-group mask |
| mask_wr_data | input | NUM_TAGS | New mask, one bit per tag |
| upd_wr_en | input | 1 | Write an update request |
| upd_wr_code | input | 2 | 0 immediate, 1 any, 2 all, 3 cancel |
| pend_tags | input | NUM_TAGS | Tags with non-barrier work still queued |
| retire_pulse | input | 1 | One or more queued commands retired this cycle |
| stat_rd_req | input | 1 | Read request for the status channel, held until acknowledged |
| stat_rd_ack | output | 1 | Read accepted this cycle |
| stat_rd_data | output | NUM_TAGS | Posted completion word |
| stat_count | output | 1 | Channel count (0 or 1) |

## Verification
Mask and update writes and retirements are registered on one clock edge. The resulting count and status word can therefore be seen from the cycle after that edge, and the bench drives on the falling edge and checks on the next falling edge. The read acknowledge depends only on the request and the registered count, so it is sampled shortly after the request is raised, in the same cycle. The emptied channel is checked one edge later. For the cases that must not post, the bench waits several cycles and checks that the count stays 0. It then applies the trigger and checks that the post appears exactly one edge after it.

// File: rtl/tag_status_pkg.sv
package tag_status_pkg;

    typedef enum logic [1:0] {
        REQ_NOW    = 2'd0,
        REQ_ANY    = 2'd1,
        REQ_ALL    = 2'd2,
        REQ_CANCEL = 2'd3
    } req_code_e;

    typedef enum logic [1:0] {
        WAIT_IDLE = 2'd0,
        WAIT_ANY  = 2'd1,
        WAIT_ALL  = 2'd2
    } wait_state_e;

endpackage

// File: rtl/tag_done_calc.sv
module tag_done_calc #(
    parameter int NUM_TAGS = 32
) (
    input  logic [NUM_TAGS-1:0] mask,
    input  logic [NUM_TAGS-1:0] pend,
    output logic [NUM_TAGS-1:0] done,
    output logic                any_done,
    output logic                all_done
);

    logic [NUM_TAGS-1:0] blocked;

    for (genvar t = 0; t < NUM_TAGS; t++) begin : g_tag
        assign done[t]    = mask[t] & ~pend[t];
        assign blocked[t] = mask[t] & pend[t];
    end

    assign any_done = |done;
    assign all_done = ~|blocked;

endmodule

// File: rtl/tag_post_ctrl.sv
module tag_post_ctrl
    import tag_status_pkg::*;
(
    input  wait_state_e wait_q,
    input  logic        upd_wr_en,
    input  logic [1:0]  upd_wr_code,
    input  logic        mask_wr_en,
    input  logic        retire_pulse,
    input  logic        any_done,
    input  logic        all_done,
    output logic        post,
    output logic        clear,
    output wait_state_e wait_d
);

    logic        retest;
    req_code_e   code;

    assign code   = req_code_e'(upd_wr_code);
    assign retest = retire_pulse | mask_wr_en;

    always_comb begin
        post   = 1'b0;
        clear  = 1'b0;
        wait_d = wait_q;
        if (upd_wr_en) begin
            clear = 1'b1;
            unique case (code)
                REQ_NOW: begin
                    post   = 1'b1;
                    wait_d = WAIT_IDLE;
                end
                REQ_ANY: begin
                    post   = any_done;
                    wait_d = any_done ? WAIT_IDLE : WAIT_ANY;
                end
                REQ_ALL: begin
                    post   = all_done;
                    wait_d = all_done ? WAIT_IDLE : WAIT_ALL;
                end
                default: wait_d = WAIT_IDLE;
            endcase
        end else if (retest) begin
            if (wait_q == WAIT_ANY && any_done) begin
                post   = 1'b1;
                wait_d = WAIT_IDLE;
            end else if (wait_q == WAIT_ALL && all_done) begin
                post   = 1'b1;
                wait_d = WAIT_IDLE;
            end
        end
    end

endmodule

// File: rtl/tag_status_unit.sv
module tag_status_unit
    import tag_status_pkg::*;
#(
    parameter int NUM_TAGS = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                mask_wr_en,
    input  logic [NUM_TAGS-1:0] mask_wr_data,
    input  logic                upd_wr_en,
    input  logic [1:0]          upd_wr_code,
    input  logic [NUM_TAGS-1:0] pend_tags,
    input  logic                retire_pulse,
    input  logic                stat_rd_req,
    output logic                stat_rd_ack,
    output logic [NUM_TAGS-1:0] stat_rd_data,
    output logic                stat_count
);

    typedef struct packed {
        logic [NUM_TAGS-1:0] mask;
        wait_state_e         waiting;
        logic [NUM_TAGS-1:0] status;
        logic                count;
    } state_t;

    state_t state_d, state_q;

    logic [NUM_TAGS-1:0] mask_eff;
    logic [NUM_TAGS-1:0] done;
    logic                any_done, all_done;
    logic                post, clear;
    wait_state_e         wait_d;

    assign mask_eff = mask_wr_en ? mask_wr_data : state_q.mask;

    tag_done_calc #(.NUM_TAGS(NUM_TAGS)) done_i (
        .mask     (mask_eff),
        .pend     (pend_tags),
        .done     (done),
        .any_done (any_done),
        .all_done (all_done)
    );

    tag_post_ctrl post_i (
        .wait_q       (state_q.waiting),
        .upd_wr_en    (upd_wr_en),
        .upd_wr_code  (upd_wr_code),
        .mask_wr_en   (mask_wr_en),
        .retire_pulse (retire_pulse),
        .any_done     (any_done),
        .all_done     (all_done),
        .post         (post),
        .clear        (clear),
        .wait_d       (wait_d)
    );

    assign stat_rd_ack  = stat_rd_req & state_q.count;
    assign stat_rd_data = state_q.status;
    assign stat_count   = state_q.count;

    always_comb begin
        state_d         = state_q;
        state_d.mask    = mask_eff;
        state_d.waiting = wait_d;
        if (stat_rd_ack || clear) begin
            state_d.count = 1'b0;
        end
        if (post) begin
            state_d.count  = 1'b1;
            state_d.status = done;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '{mask: '0, waiting: WAIT_IDLE, status: '0, count: 1'b0};
        end else begin
            state_q <= state_d;
        end
    end

    p_imm_post_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_wr_en && upd_wr_code == 2'd0)
        |=> (stat_count && stat_rd_data == $past(mask_eff & ~pend_tags)));

    p_all_exact_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (post && !upd_wr_en && state_q.waiting == WAIT_ALL) |-> (done == mask_eff));

    p_cancel_empty_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_wr_en && upd_wr_code == 2'd3) |=> (!stat_count && state_q.waiting == WAIT_IDLE));

    p_idle_after_post_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (post && upd_wr_code != 2'd3) |=> (state_q.waiting == WAIT_IDLE));

    p_no_spurious_post_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!retire_pulse && !mask_wr_en && !upd_wr_en) |=> !$rose(stat_count));

    p_read_drains_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd_ack && !post) |=> !stat_count);

endmodule

// File: tb/tag_status_unit_tb.sv
module tag_status_unit_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int NT         = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          mask_wr_en = 1'b0;
    logic [NT-1:0] mask_wr_data = '0;
    logic          upd_wr_en = 1'b0;
    logic [1:0]    upd_wr_code = 2'd0;
    logic [NT-1:0] pend_tags = '0;
    logic          retire_pulse = 1'b0;
    logic          stat_rd_req = 1'b0;
    logic          stat_rd_ack;
    logic [NT-1:0] stat_rd_data;
    logic          stat_count;

    int checks = 0;
    int errors = 0;
    bit done_flag = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tag_status_unit #(.NUM_TAGS(NT)) dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .mask_wr_en   (mask_wr_en),
        .mask_wr_data (mask_wr_data),
        .upd_wr_en    (upd_wr_en),
        .upd_wr_code  (upd_wr_code),
        .pend_tags    (pend_tags),
        .retire_pulse (retire_pulse),
        .stat_rd_req  (stat_rd_req),
        .stat_rd_ack  (stat_rd_ack),
        .stat_rd_data (stat_rd_data),
        .stat_count   (stat_count)
    );

    task automatic check(input string req, input logic [NT-1:0] act, input logic [NT-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic write_mask(input logic [NT-1:0] m);
        mask_wr_en = 1'b1;
        mask_wr_data = m;
        @(negedge clk);
        mask_wr_en = 1'b0;
    endtask

    task automatic write_upd(input logic [1:0] c);
        upd_wr_en = 1'b1;
        upd_wr_code = c;
        @(negedge clk);
        upd_wr_en = 1'b0;
    endtask

    task automatic pulse_retire();
        retire_pulse = 1'b1;
        @(negedge clk);
        retire_pulse = 1'b0;
    endtask

    // R11: read a present word; ack is due in the request cycle, empty after the edge
    task automatic read_word(input string req, input logic [NT-1:0] exp);
        stat_rd_req = 1'b1;
        #1;
        check({req, "/R11 ack"}, stat_rd_ack, 1);
        check(req, stat_rd_data, exp);
        @(negedge clk);
        stat_rd_req = 1'b0;
        check("R11 drained", stat_count, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done_flag) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        stat_rd_req = 1'b1;
        #1;
        check("R1 count", stat_count, 0);
        check("R1 no ack", stat_rd_ack, 0);
        stat_rd_req = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 count after release", stat_count, 0);
        write_upd(2'd2);
        check("R1 mask zero gives all-done post", stat_count, 1);
        read_word("R1 zero mask word", 0);

        // Sweep of R2..R5, R8: low four tags of mask and pending
        for (int code = 0; code < 3; code++) begin
            for (int m = 0; m < 16; m++) begin
                for (int p = 0; p < 16; p++) begin
                    logic [NT-1:0] mv, pv, dv;
                    bit now_post;
                    mv = NT'(m);
                    pv = NT'(p);
                    dv = mv & ~pv;
                    now_post = (code == 0) || (code == 1 && dv != 0) || (code == 2 && dv == mv);
                    pend_tags = pv;
                    write_mask(mv);
                    write_upd(2'(code));
                    if (now_post) begin
                        check("R3/R4/R5 immediate post", stat_count, 1);
                        read_word("R2 completed word", dv);
                    end else begin
                        check("R4/R5 waits", stat_count, 0);
                        pend_tags = '0;
                        pulse_retire();
                        if (code == 1 && m == 0) begin
                            check("R4 still waiting", stat_count, 0);
                        end else begin
                            check("R8 post on retire", stat_count, 1);
                            read_word("R8 retire word", mv);
                        end
                    end
                end
            end
        end

        // R9: mask rewrite re-tests a waiting all request
        pend_tags = 32'h1;
        write_mask(32'h1);
        write_upd(2'd2);
        check("R9 waiting", stat_count, 0);
        write_mask(32'h6);
        check("R9 post on mask write", stat_count, 1);
        read_word("R9 word", 32'h6);

        // R7: no second post after a conditional post
        pend_tags = 32'h0;
        write_mask(32'h3);
        write_upd(2'd1);
        read_word("R7 first word", 32'h3);
        pulse_retire();
        write_mask(32'h7);
        check("R7 no repost", stat_count, 0);

        // R10: pending change alone does nothing, then R8 retire posts
        pend_tags = 32'hF;
        write_mask(32'h5);
        write_upd(2'd2);
        pend_tags = 32'h0;
        repeat (4) @(negedge clk);
        check("R10 no post without trigger", stat_count, 0);
        pulse_retire();
        check("R8 post after retire", stat_count, 1);
        read_word("R8 word", 32'h5);

        // R6: new update write discards an unread word
        pend_tags = 32'h0;
        write_mask(32'h9);
        write_upd(2'd0);
        check("R6 posted", stat_count, 1);
        pend_tags = 32'h1;
        write_upd(2'd2);
        check("R6 old word discarded", stat_count, 0);

        // R12: cancel empties and leaves nothing waiting
        write_upd(2'd0);
        check("R12 setup post", stat_count, 1);
        write_upd(2'd3);
        check("R12 emptied", stat_count, 0);
        pend_tags = 32'h0;
        pulse_retire();
        check("R12 nothing waiting", stat_count, 0);

        // R11: a held read stalls until the post arrives
        pend_tags = 32'h8;
        write_mask(32'h8);
        write_upd(2'd1);
        stat_rd_req = 1'b1;
        for (int i = 0; i < 3; i++) begin
            #1;
            check("R11 stall", stat_rd_ack, 0);
            @(negedge clk);
        end
        pend_tags = 32'h0;
        retire_pulse = 1'b1;
        @(negedge clk);
        retire_pulse = 1'b0;
        #1;
        check("R11 ack after post", stat_rd_ack, 1);
        check("R11 data", stat_rd_data, 32'h8);
        @(negedge clk);
        stat_rd_req = 1'b0;
        check("R11 empty after read", stat_count, 0);

        done_flag = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule